// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns a host erase request into a stream of erase commands for a page-organised serial flash. The host hands over a start byte address, a byte count and the page geometry: bytes per page, the left shift that turns a page index into a device address, and the total device size in bytes. The block first validates the request. It then works through the range one step at a time. Each step erases either a single page or an aligned group of eight pages.

After every erase command the block polls the device status byte until the ready bit appears. It waits a programmable number of cycles between polls. A separate timeout budget ends the job with an error if the device never becomes ready. The block talks to a byte-wide SPI master: it presents one byte at a time with a valid flag and a chip-select level, and the master reports each finished byte exchange with a one-cycle strobe that carries the received byte.

The page size need not be a power of two. Validation therefore uses a small sequential divider that turns the byte address and the byte count into a page index, a page count and two remainders.

Top module: `flash_erase_seq`

## Requirements
- R1: A request with zero length is accepted and completes in the cycle after acceptance, with `done` high, `err` = 0 and no chip-select activity.
- R2: A non-empty request whose address plus length is larger than the device size completes in the cycle after acceptance with `err` = 2 and no SPI traffic.
- R3: A non-empty, in-range request whose address or length is not a whole multiple of the page size completes with `err` = 1 and no SPI traffic.
- R4: A step uses the eight-page opcode 0x50 when the current page index has its three low bits clear and at least eight pages remain. Every other step uses the single-page opcode 0x81.
- R5: An erase command is a frame of exactly four bytes sent under one continuous chip-select: the opcode, device address bits 23:16, device address bits 15:8, and 0x00. The device address is the page index shifted left by the configured shift. A byte stays stable on `spi_tx_byte` until its exchange completes.
- R6: After each command the block sends status frames of two bytes, 0xD7 then 0x00, with chip-select low between frames. The byte received during the second exchange counts as ready when bit 7 is 1, and only a ready status lets the sequence move on.
- R7: Before every status frame, chip-select stays low for at least `cfg_poll_gap` cycles.
- R8: An eight-page step advances the page index by 8 and reduces the remaining count by 8. A single-page step changes each by 1. The job finishes with `err` = 0 after the ready status that follows the last step. `done` is a single-cycle pulse.
- R9: If `cfg_timeout` cycles pass after a command without a ready status, the job ends with `err` = 3 and no further command is sent.
- R10: `req_ready` is high only while idle, with chip-select and byte-valid low. A `req_valid` raised during a job is ignored and does not change the commands issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Block idle; request taken this cycle if valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Byte count to erase |
| cfg_page_bytes | input | PS_W | Bytes per page |
| cfg_page_shift | input | SH_W | Left shift from page index to device address |
| cfg_dev_bytes | input | ADDR_W+1 | Device size in bytes |
| cfg_poll_gap | input | GAP_W | Minimum idle cycles before each status frame |
| cfg_timeout | input | TMO_W | Cycle budget for the ready status after a command |
| spi_cs | output | 1 | Chip-select, high while a frame is in progress |
| spi_tx_valid | output | 1 | Byte on spi_tx_byte awaits exchange |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_done | input | 1 | One-cycle strobe: current byte exchange finished |
| spi_rx_byte | input | 8 | Byte received in the finished exchange |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result code with done: 0 ok, 1 alignment, 2 range, 3 timeout |

## Verification
Two functions can fall due in the same cycle: the end of the poll gap, which would open a new status frame, and the end of the ready timeout, which must close the job. The bench models a device that never reports ready. It sweeps the timeout limit in small steps against a fixed poll gap, so that some limits land exactly on a gap boundary. For every limit it requires error code 3, exactly one erase command and only well-formed frames. A second overlap is a new request arriving while a job is running. The bench raises `req_valid` with unrelated operands during the division phase and requires both `req_ready` low and an unchanged command list.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam logic [7:0] OP_ERASE_GROUP = 8'h50;
  localparam logic [7:0] OP_ERASE_ONE   = 8'h81;
  localparam logic [7:0] OP_STATUS      = 8'hD7;
  localparam int         GROUP_PAGES    = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_DIV_A, S_DIV_L, S_LOAD, S_CMD,
    S_GAP, S_POLL_OP, S_POLL_DAT, S_FIN
  } seq_state_e;

  localparam logic [1:0] E_OK    = 2'd0;
  localparam logic [1:0] E_ALIGN = 2'd1;
  localparam logic [1:0] E_RANGE = 2'd2;
  localparam logic [1:0] E_TMO   = 2'd3;
endpackage

// File: rtl/fes_divider.sv
module fes_divider #(
  parameter int N = 24,
  parameter int D = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [D-1:0] divisor,
  output logic         done,
  output logic [N-1:0] quot,
  output logic [D-1:0] rem
);
  localparam int CW = $clog2(N + 1);

  logic [D:0]    acc;
  logic [N-1:0]  q;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [D:0]    trial;
  logic          fits;

  assign trial = {acc[D-1:0], q[N-1]};
  assign fits  = trial >= {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      q    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc  <= '0;
        q    <= dividend;
        cnt  <= CW'(N);
        busy <= 1'b1;
      end else if (busy) begin
        acc <= fits ? (trial - {1'b0, divisor}) : trial;
        q   <= {q[N-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = q;
  assign rem  = acc[D-1:0];
endmodule

// File: rtl/fes_poll_timer.sv
module fes_poll_timer #(
  parameter int GAP_W = 16,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gap_load,
  input  logic [GAP_W-1:0] gap_len,
  input  logic             tmo_clear,
  input  logic             tmo_run,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             gap_zero,
  output logic             tmo_hit
);
  logic [GAP_W-1:0] gap_cnt;
  logic [TMO_W-1:0] tmo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
    end else if (gap_load) begin
      gap_cnt <= gap_len;
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tmo_clear) begin
      tmo_cnt <= '0;
    end else if (tmo_run && !tmo_hit) begin
      tmo_cnt <= tmo_cnt + 1'b1;
    end
  end

  assign gap_zero = (gap_cnt == '0);
  assign tmo_hit  = (tmo_cnt >= tmo_limit);
endmodule

// File: rtl/fes_cmd_build.sv
module fes_cmd_build
  import fes_pkg::*;
#(
  parameter int PW   = 24,
  parameter int SH_W = 4
) (
  input  logic [PW-1:0]   page_idx,
  input  logic [PW-1:0]   pages_left,
  input  logic [SH_W-1:0] shift,
  output logic            use_group,
  output logic [7:0]      opcode,
  output logic [7:0]      addr_hi,
  output logic [7:0]      addr_mid
);
  localparam int WIDE = PW + (1 << SH_W);

  logic [WIDE-1:0] dev_addr;

  always_comb begin
    use_group = (page_idx[2:0] == 3'b000) && (pages_left >= PW'(GROUP_PAGES));
    opcode    = use_group ? OP_ERASE_GROUP : OP_ERASE_ONE;
    dev_addr  = {{(WIDE-PW){1'b0}}, page_idx} << shift;
    addr_hi   = dev_addr[23:16];
    addr_mid  = dev_addr[15:8];
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PS_W   = 11,
  parameter int SH_W   = 4,
  parameter int GAP_W  = 16,
  parameter int TMO_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  input  logic [PS_W-1:0]   cfg_page_bytes,
  input  logic [SH_W-1:0]   cfg_page_shift,
  input  logic [ADDR_W:0]   cfg_dev_bytes,
  input  logic [GAP_W-1:0]  cfg_poll_gap,
  input  logic [TMO_W-1:0]  cfg_timeout,
  output logic              spi_cs,
  output logic              spi_tx_valid,
  output logic [7:0]        spi_tx_byte,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx_byte,
  output logic              done,
  output logic [1:0]        err
);
  localparam logic [ADDR_W-1:0] STEP_GROUP = ADDR_W'(GROUP_PAGES);
  localparam logic [ADDR_W-1:0] STEP_ONE   = ADDR_W'(1);

  seq_state_e        state;
  logic [ADDR_W-1:0] len_q;
  logic [PS_W-1:0]   ps_q;
  logic [SH_W-1:0]   sh_q;
  logic [GAP_W-1:0]  gap_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [ADDR_W-1:0] page_q;
  logic [ADDR_W-1:0] left_q;
  logic [7:0]        b1_q, b2_q;
  logic              grp_q;
  logic [1:0]        idx_q;
  logic              cs_q, txv_q, done_q;
  logic [7:0]        txb_q;
  logic [1:0]        err_q;

  logic              div_start;
  logic [ADDR_W-1:0] div_in;
  logic              div_done;
  logic [ADDR_W-1:0] div_quot;
  logic [PS_W-1:0]   div_rem;

  logic              bld_grp;
  logic [7:0]        bld_op, bld_hi, bld_mid;

  logic              gap_load, tmo_clear, tmo_run, gap_zero, tmo_hit;
  logic [ADDR_W:0]   req_end;
  logic              cmd_last, poll_retry;

  fes_divider #(.N(ADDR_W), .D(PS_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (div_in),
    .divisor  (ps_q),
    .done     (div_done),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  fes_cmd_build #(.PW(ADDR_W), .SH_W(SH_W)) u_build (
    .page_idx   (page_q),
    .pages_left (left_q),
    .shift      (sh_q),
    .use_group  (bld_grp),
    .opcode     (bld_op),
    .addr_hi    (bld_hi),
    .addr_mid   (bld_mid)
  );

  fes_poll_timer #(.GAP_W(GAP_W), .TMO_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .gap_load  (gap_load),
    .gap_len   (gap_q),
    .tmo_clear (tmo_clear),
    .tmo_run   (tmo_run),
    .tmo_limit (tmo_q),
    .gap_zero  (gap_zero),
    .tmo_hit   (tmo_hit)
  );

  assign req_end    = {1'b0, req_addr} + {1'b0, req_len};
  assign cmd_last   = (state == S_CMD) && spi_done && (idx_q == 2'd3);
  assign poll_retry = (state == S_POLL_DAT) && spi_done && !spi_rx_byte[7];
  assign gap_load   = cmd_last || poll_retry;
  assign tmo_clear  = (state == S_LOAD);
  assign tmo_run    = (state == S_GAP) || (state == S_POLL_OP) || (state == S_POLL_DAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      len_q     <= '0;
      ps_q      <= '0;
      sh_q      <= '0;
      gap_q     <= '0;
      tmo_q     <= '0;
      page_q    <= '0;
      left_q    <= '0;
      b1_q      <= '0;
      b2_q      <= '0;
      grp_q     <= 1'b0;
      idx_q     <= '0;
      cs_q      <= 1'b0;
      txv_q     <= 1'b0;
      txb_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= E_OK;
      div_start <= 1'b0;
      div_in    <= '0;
    end else begin
      done_q    <= 1'b0;
      div_start <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            len_q <= req_len;
            ps_q  <= cfg_page_bytes;
            sh_q  <= cfg_page_shift;
            gap_q <= cfg_poll_gap;
            tmo_q <= cfg_timeout;
            if (req_len == '0) begin
              state  <= S_FIN;
              done_q <= 1'b1;
              err_q  <= E_OK;
            end else if (req_end > cfg_dev_bytes) begin
              state  <= S_FIN;
              done_q <= 1'b1;
              err_q  <= E_RANGE;
            end else begin
              div_start <= 1'b1;
              div_in    <= req_addr;
              state     <= S_DIV_A;
            end
          end
        end
        S_DIV_A: begin
          if (div_done) begin
            if (div_rem != '0) begin
              state  <= S_FIN;
              done_q <= 1'b1;
              err_q  <= E_ALIGN;
            end else begin
              page_q    <= div_quot;
              div_start <= 1'b1;
              div_in    <= len_q;
              state     <= S_DIV_L;
            end
          end
        end
        S_DIV_L: begin
          if (div_done) begin
            if (div_rem != '0) begin
              state  <= S_FIN;
              done_q <= 1'b1;
              err_q  <= E_ALIGN;
            end else begin
              left_q <= div_quot;
              state  <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          b1_q  <= bld_hi;
          b2_q  <= bld_mid;
          grp_q <= bld_grp;
          idx_q <= 2'd0;
          cs_q  <= 1'b1;
          txv_q <= 1'b1;
          txb_q <= bld_op;
          state <= S_CMD;
        end
        S_CMD: begin
          if (spi_done) begin
            if (idx_q == 2'd3) begin
              cs_q  <= 1'b0;
              txv_q <= 1'b0;
              if (grp_q) begin
                page_q <= page_q + STEP_GROUP;
                left_q <= left_q - STEP_GROUP;
              end else begin
                page_q <= page_q + STEP_ONE;
                left_q <= left_q - STEP_ONE;
              end
              state <= S_GAP;
            end else begin
              idx_q <= idx_q + 2'd1;
              case (idx_q)
                2'd0:    txb_q <= b1_q;
                2'd1:    txb_q <= b2_q;
                default: txb_q <= 8'h00;
              endcase
            end
          end
        end
        S_GAP: begin
          if (tmo_hit) begin
            state  <= S_FIN;
            done_q <= 1'b1;
            err_q  <= E_TMO;
          end else if (gap_zero) begin
            cs_q  <= 1'b1;
            txv_q <= 1'b1;
            txb_q <= OP_STATUS;
            state <= S_POLL_OP;
          end
        end
        S_POLL_OP: begin
          if (spi_done) begin
            txb_q <= 8'h00;
            state <= S_POLL_DAT;
          end
        end
        S_POLL_DAT: begin
          if (spi_done) begin
            cs_q  <= 1'b0;
            txv_q <= 1'b0;
            if (spi_rx_byte[7]) begin
              if (left_q == '0) begin
                state  <= S_FIN;
                done_q <= 1'b1;
                err_q  <= E_OK;
              end else begin
                state <= S_LOAD;
              end
            end else begin
              state <= S_GAP;
            end
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == S_IDLE);
  assign spi_cs       = cs_q;
  assign spi_tx_valid = txv_q;
  assign spi_tx_byte  = txb_q;
  assign done         = done_q;
  assign err          = err_q;
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] req_len,
  input logic [ADDR_W:0]   cfg_dev_bytes,
  input logic              spi_cs,
  input logic              spi_tx_valid,
  input logic [7:0]        spi_tx_byte,
  input logic              spi_done,
  input logic              done,
  input logic [1:0]        err
);
  assert_zero_len_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == '0) |=> (done && err == 2'd0 && !spi_cs));

  assert_range_reject_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len != '0 &&
     ({1'b0, req_addr} + {1'b0, req_len}) > cfg_dev_bytes) |=> (done && err == 2'd2 && !spi_cs));

  assert_byte_framed_R5: assert property (@(posedge clk) disable iff (rst)
    spi_tx_valid |-> spi_cs);

  assert_byte_held_R5: assert property (@(posedge clk) disable iff (rst)
    (spi_tx_valid && !spi_done) |=> (spi_tx_valid && $stable(spi_tx_byte)));

  assert_cs_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs) |-> $past(spi_done));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!spi_cs && !spi_tx_valid));
endmodule

bind flash_erase_seq fes_checker #(.ADDR_W(ADDR_W)) u_fes_checker (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_len       (req_len),
  .cfg_dev_bytes (cfg_dev_bytes),
  .spi_cs        (spi_cs),
  .spi_tx_valid  (spi_tx_valid),
  .spi_tx_byte   (spi_tx_byte),
  .spi_done      (spi_done),
  .done          (done),
  .err           (err)
);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int ADDR_W = 24;
  localparam int PS_W   = 11;
  localparam int SH_W   = 4;
  localparam int GAP_W  = 16;
  localparam int TMO_W  = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [ADDR_W-1:0] req_len = '0;
  logic [PS_W-1:0]   cfg_page_bytes = '0;
  logic [SH_W-1:0]   cfg_page_shift = '0;
  logic [ADDR_W:0]   cfg_dev_bytes = '0;
  logic [GAP_W-1:0]  cfg_poll_gap = '0;
  logic [TMO_W-1:0]  cfg_timeout = '0;
  logic              spi_cs, spi_tx_valid;
  logic [7:0]        spi_tx_byte;
  logic              spi_done = 1'b0;
  logic [7:0]        spi_rx_byte = '0;
  logic              done;
  logic [1:0]        err;

  always #5 clk = ~clk;

  flash_erase_seq dut (.*);

  int vecs = 0;
  int miss = 0;

  // device model state
  logic [7:0]  fr [0:7];
  int          fb = 0;
  int          low_run = 0, low_at_start = 0;
  logic        cs_prev = 1'b0;
  int          lat = 0;
  logic [31:0] cmd_log [0:127];
  int          cmd_n = 0, poll_n = 0, poll_since = 0;
  int          busy_polls = 0, cur_gap = 0;
  int          bad_frames = 0, gap_viol = 0;

  // expected commands
  logic [31:0] exp_cmd [0:127];
  int          exp_n = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      spi_done = 1'b0;
      fb = 0; low_run = 0; cs_prev = 1'b0; lat = 0;
    end else begin
      if (spi_cs && !cs_prev) begin
        fb = 0;
        low_at_start = low_run;
      end
      if (!spi_cs && cs_prev) begin
        if (fb == 4 && fr[0] != 8'hD7) begin
          if (cmd_n < 128) cmd_log[cmd_n] = {fr[0], fr[1], fr[2], fr[3]};
          cmd_n++;
          poll_since = 0;
        end else if (fb == 2 && fr[0] == 8'hD7 && fr[1] == 8'h00) begin
          poll_n++;
          poll_since++;
          if (low_at_start < cur_gap) gap_viol++;
        end else begin
          bad_frames++;
        end
      end
      if (spi_done) begin
        spi_done = 1'b0;
      end else if (spi_tx_valid) begin
        if (lat == 0) begin
          if (fb < 8) fr[fb] = spi_tx_byte;
          if (fb == 1 && fr[0] == 8'hD7)
            spi_rx_byte = (poll_since >= busy_polls) ? (8'h80 | 8'($urandom_range(0, 127)))
                                                     : 8'($urandom_range(0, 127));
          else
            spi_rx_byte = 8'($urandom_range(0, 255));
          fb++;
          spi_done = 1'b1;
          lat = $urandom_range(0, 2);
        end else begin
          lat--;
        end
      end
      if (!spi_cs) low_run++; else low_run = 0;
      cs_prev = spi_cs;
    end
  end

  function automatic void build_exp(input int a, input int l, input int ps, input int sh);
    int pg, left, da;
    bit grp;
    pg = a / ps; left = l / ps; exp_n = 0;
    while (left > 0) begin
      grp = (pg % 8 == 0) && (left >= 8);
      da  = pg << sh;
      exp_cmd[exp_n] = {grp ? 8'h50 : 8'h81, da[23:16], da[15:8], 8'h00};
      exp_n++;
      if (grp) begin pg += 8; left -= 8; end
      else begin pg += 1; left -= 1; end
    end
  endfunction

  task automatic do_case(input int a, input int l, input int ps, input int sh, input int devb,
                         input int gap, input int tmo, input int busy, input bit meddle);
    int cyc, exp_err, got_err;
    bit ready_seen;
    string tag;
    ready_seen = 1'b0;
    if (l == 0) begin exp_err = 0; tag = "R1"; end
    else if (a + l > devb) begin exp_err = 2; tag = "R2"; end
    else if ((a % ps) != 0 || (l % ps) != 0) begin exp_err = 1; tag = "R3"; end
    else if (busy > 100000) begin exp_err = 3; tag = "R9"; end
    else begin exp_err = 0; tag = "R8"; end
    build_exp(a, l, ps, sh);

    @(negedge clk);
    cmd_n = 0; poll_n = 0; poll_since = 0; bad_frames = 0; gap_viol = 0;
    busy_polls = busy; cur_gap = gap;
    req_addr = ADDR_W'(a); req_len = ADDR_W'(l);
    cfg_page_bytes = PS_W'(ps); cfg_page_shift = SH_W'(sh);
    cfg_dev_bytes = (ADDR_W+1)'(devb); cfg_poll_gap = GAP_W'(gap); cfg_timeout = TMO_W'(tmo);
    chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      if (meddle && cyc == 3) begin
        req_valid = 1'b1; req_addr = ADDR_W'(ps); req_len = ADDR_W'(ps);
      end
      if (meddle && cyc >= 3 && cyc < 7 && req_ready) ready_seen = 1'b1;
      if (meddle && cyc == 7) req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    got_err = int'(err);
    chk(done == 1'b1, tag, "done seen (watchdog)", int'(done), 1);
    @(negedge clk); @(negedge clk);

    chk(got_err == exp_err, tag, "result code", got_err, exp_err);
    if (l == 0) begin
      chk(cyc == 1, "R1", "cycles to done", cyc, 1);
      chk(cmd_n == 0 && poll_n == 0, "R1", "frames on empty request", cmd_n + poll_n, 0);
    end else if (exp_err == 2) begin
      chk(cyc == 1, "R2", "cycles to done", cyc, 1);
      chk(cmd_n == 0 && poll_n == 0, "R2", "frames on range error", cmd_n + poll_n, 0);
    end else if (exp_err == 1) begin
      chk(cmd_n == 0 && poll_n == 0, "R3", "frames on alignment error", cmd_n + poll_n, 0);
    end else if (exp_err == 3) begin
      chk(cmd_n == 1, "R9", "commands before timeout", cmd_n, 1);
    end else begin
      chk(cmd_n == exp_n, "R8", "command count", cmd_n, exp_n);
      for (int i = 0; i < exp_n && i < cmd_n; i++) begin
        chk(cmd_log[i][31:24] == exp_cmd[i][31:24], "R4", "opcode", int'(cmd_log[i][31:24]), int'(exp_cmd[i][31:24]));
        chk(cmd_log[i] == exp_cmd[i], "R5", "command bytes", int'(cmd_log[i]), int'(exp_cmd[i]));
      end
      chk(poll_n == exp_n * (busy + 1), "R6", "status frames", poll_n, exp_n * (busy + 1));
    end
    chk(gap_viol == 0, "R7", "short gaps before status frame", gap_viol, 0);
    chk(bad_frames == 0, "R5", "malformed frames", bad_frames, 0);
    if (meddle) chk(!ready_seen, "R10", "ready while busy", int'(ready_seen), 0);
  endtask

  int ps_tab [0:3] = '{256, 264, 512, 528};
  int sh_tab [0:3] = '{8, 9, 9, 10};

  initial begin
    repeat (200000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    int k, ps, sh, apg, lpg, a, l;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !spi_cs && !spi_tx_valid && !done, "R10", "reset state",
        int'({req_ready, spi_cs, spi_tx_valid, done}), 8);

    // directed corner cases
    do_case(264 * 5, 0, 264, 9, 264 * 64, 2, 100000, 1, 1'b0);            // R1 empty
    do_case(264 * 60, 264 * 4, 264, 9, 264 * 64, 2, 100000, 0, 1'b0);     // ends exactly at device size
    do_case(264 * 60, 264 * 5, 264, 9, 264 * 64, 2, 100000, 0, 1'b0);     // R2 one page past
    do_case(256 * 3 + 1, 256, 256, 8, 256 * 64, 2, 100000, 0, 1'b0);      // R3 address misaligned
    do_case(256 * 3, 300, 256, 8, 256 * 64, 2, 100000, 0, 1'b0);          // R3 length misaligned
    do_case(512 * 8, 512 * 16, 512, 9, 512 * 64, 3, 100000, 2, 1'b1);     // R4 two groups, R10 meddle
    do_case(528 * 5, 528 * 12, 528, 10, 528 * 64, 1, 100000, 1, 1'b0);    // R4 pages then group then page
    do_case(256 * 8, 256 * 7, 256, 8, 256 * 64, 0, 100000, 0, 1'b0);      // R4 aligned but short
    for (int t = 20; t <= 44; t += 3)                                     // R9 sweep against gap
      do_case(264 * 2, 264, 264, 9, 264 * 64, 3, t, 1000000, 1'b0);

    // constrained random
    for (int n = 0; n < 45; n++) begin
      k   = $urandom_range(0, 3);
      ps  = ps_tab[k]; sh = sh_tab[k];
      apg = ($urandom_range(0, 3) == 0) ? 8 * $urandom_range(0, 6) : $urandom_range(0, 63);
      lpg = $urandom_range(0, 20);
      a   = apg * ps; l = lpg * ps;
      if ($urandom_range(0, 7) == 0) a += $urandom_range(1, ps - 1);
      if ($urandom_range(0, 7) == 0) l += $urandom_range(1, ps - 1);
      do_case(a, l, ps, sh, ps * 64, $urandom_range(0, 6), 100000, $urandom_range(0, 2),
              (n % 5 == 0) && l > 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule